// File: doc/BRIEF.md
# Single-Bus Stack Processor Datapath

This block is the register and bus datapath of a small 8-bit stack processor. An external sequencer supplies one 16-bit control word per clock. The datapath holds these registers:

- an instruction pointer and a stack pointer, which can both drive and load the bus;
- a carry flag;
- an instruction latch and an address latch;
- three operand latches: X, Y and Z.

One shared 8-bit data bus links all of them. Five sources can drive the bus: the two pointers, an adder (X + Y + carry-in), a bitwise NAND of Y and Z, and the external memory read port. When no source drives it, the bus reads as all ones.

The address latch feeds the memory address port. The memory is external, with a combinational read port and a synchronous write port. The write data is always the current bus value. A 5-bit step counter advances every cycle, and a control bit can clear it. The step counter, the instruction latch and the carry flag are the outputs a microcode sequencer would use. No register can be read directly. To copy an operand latch onto the bus, the microcode routes it through the adder or the NAND.

Top module: `sbp_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, the instruction pointer, stack pointer, carry flag, instruction latch, address latch, X, Y, Z and the step counter all become zero. So `mem_addr`, `insn_o`, `carry_o` and `step_o` read 0 after that edge.
- R2: The `ctrl_word` bits, from bit 15 down to bit 0, mean:
  - bit 15: load the instruction pointer
  - bit 14: load the stack pointer
  - bit 13: load the carry flag
  - bit 12: load the instruction latch
  - bit 11: load the address latch
  - bit 10: load X
  - bit 9: load Y
  - bit 8: load Z
  - bit 7: memory write
  - bit 6: memory drives the bus
  - bit 5: clear the step counter
  - bit 4: carry-in of 1
  - bit 3: instruction pointer drives the bus
  - bit 2: stack pointer drives the bus
  - bit 1: adder drives the bus
  - bit 0: NAND drives the bus
  
  At most one of the driver bits (6, 3, 2, 1, 0) may be set in any cycle.
- R3: When none of bits 6, 3, 2, 1 or 0 is set, the bus (seen on `mem_wdata`) reads 0xFF.
- R4: When bit 3 or bit 2 is set, the bus carries the instruction pointer or the stack pointer. When bit 15 or bit 14 is set, that pointer loads the bus value at the rising edge; otherwise it holds.
- R5: Each latch loads the bus value at the rising edge when its load bit is set, and holds otherwise. The address latch appears on `mem_addr` and the instruction latch on `insn_o`.
- R6: When bit 1 is set, the bus carries (X + Y + c) mod 256, where c is bit 4 of the same word.
- R7: When bit 0 is set, the bus carries the bitwise inverse of (Y AND Z).
- R8: When bits 13 and 1 are both set, the carry flag loads the carry-out of X + Y + c. When bit 13 is clear, the carry flag holds.
- R9: When bit 13 is set and bit 1 is clear, the carry flag loads 1 if ~(Y AND Z) equals 0x00, and 0 otherwise.
- R10: When bit 6 is set, the bus carries `mem_rdata`. `mem_we` equals bit 7, and `mem_wdata` always carries the bus value.
- R11: The step counter on `step_o` advances by one each cycle and wraps from 31 to 0. When bit 5 is set, it reads 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Control word for this cycle |
| mem_rdata | input | 8 | Combinational memory read data |
| mem_addr | output | 8 | Memory address from the address latch |
| mem_wdata | output | 8 | Memory write data, equal to the bus |
| mem_we | output | 1 | Memory write strobe |
| insn_o | output | 8 | Instruction latch contents |
| carry_o | output | 1 | Carry flag |
| step_o | output | 5 | Step counter |

## Verification
The assertions run on every cycle and check these behaviours:
- the single-driver rule on the bus;
- the all-ones idle bus;
- the memory path onto the bus and the write strobe;
- the latch loads seen on the address and instruction outputs;
- the carry flag holding when it is not loaded;
- the step counter's increment and clear;
- the reset state.

Only the bench's scenarios can show the arithmetic: the sum with and without carry-in, its carry-out, the NAND and its zero flag. The same holds for the pointer round trips and for the values held in the operand latches. Those values are visible only when they pass through the adder or the NAND, so the bench's reference model follows them across cycles.

// File: rtl/sbp_pkg.sv
// Package: shared control-word layout and bus-source indices for the
// single-bus datapath. Assumes a 16-bit control word, MSB first.
package sbp_pkg;

    localparam int CTRL_W  = 16;
    localparam int NUM_DRV = 5;
    localparam int NUM_REG = 7;

    // Bus source slots of the driver multiplexer.
    localparam int DV_NAND = 0;
    localparam int DV_SUM  = 1;
    localparam int DV_SPTR = 2;
    localparam int DV_IPTR = 3;
    localparam int DV_MEM  = 4;

    // Bus-loaded register slots of the register bank.
    localparam int RG_IPTR = 0;
    localparam int RG_SPTR = 1;
    localparam int RG_INSN = 2;
    localparam int RG_ADDR = 3;
    localparam int RG_X    = 4;
    localparam int RG_Y    = 5;
    localparam int RG_Z    = 6;

    // Field order follows control-word bit 15 down to bit 0.
    typedef struct packed {
        logic ld_iptr;
        logic ld_sptr;
        logic ld_carry;
        logic ld_insn;
        logic ld_addr;
        logic ld_x;
        logic ld_y;
        logic ld_z;
        logic mem_wr;
        logic drv_mem;
        logic clr_step;
        logic cin_set;
        logic drv_iptr;
        logic drv_sptr;
        logic drv_sum;
        logic drv_nand;
    } ctrl_t;

    // Gather the bus-driver enables into slot order.
    function automatic logic [NUM_DRV-1:0] drv_vec(input ctrl_t c);
        logic [NUM_DRV-1:0] v;
        v          = '0;
        v[DV_NAND] = c.drv_nand;
        v[DV_SUM]  = c.drv_sum;
        v[DV_SPTR] = c.drv_sptr;
        v[DV_IPTR] = c.drv_iptr;
        v[DV_MEM]  = c.drv_mem;
        return v;
    endfunction

    // Gather the register load enables into slot order.
    function automatic logic [NUM_REG-1:0] ld_vec(input ctrl_t c);
        logic [NUM_REG-1:0] v;
        v          = '0;
        v[RG_IPTR] = c.ld_iptr;
        v[RG_SPTR] = c.ld_sptr;
        v[RG_INSN] = c.ld_insn;
        v[RG_ADDR] = c.ld_addr;
        v[RG_X]    = c.ld_x;
        v[RG_Y]    = c.ld_y;
        v[RG_Z]    = c.ld_z;
        return v;
    endfunction

endpackage

// File: rtl/sbp_alu.sv
// Module: operand unit. Produces X+Y+cin with carry-out and ~(Y&Z) with a
// zero flag. Purely combinational; assumes the operands come from latches.
module sbp_alu #(
    parameter int W = 8
) (
    input  logic         cin,
    input  logic [W-1:0] opx,
    input  logic [W-1:0] opy,
    input  logic [W-1:0] opz,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic [W-1:0] nand_q,
    output logic         zero
);

    logic [W:0] wide;

    // Add with one extra bit to capture the carry-out.
    always_comb begin
        wide = {1'b0, opx} + {1'b0, opy} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
    end

    // Bitwise NAND and its all-zero detector.
    always_comb begin
        nand_q = ~(opy & opz);
        zero   = (nand_q == '0);
    end

endmodule

// File: rtl/sbp_bus_mux.sv
// Module: shared-bus driver selection. Gates each source by its enable and
// merges them; with no enable the bus floats high (all ones). Assumes at
// most one enable per cycle; overlapping enables are flagged by the checker.
module sbp_bus_mux #(
    parameter int W = 8,
    parameter int N = 5
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] gated;

    // Mask each source with its own enable.
    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = src[g] & {W{sel[g]}};
    end

    // Merge gated sources; the pull-up applies when nothing drives.
    always_comb begin
        bus = '0;
        for (int k = 0; k < N; k++) begin
            bus = bus | gated[k];
        end
        if (sel == '0) begin
            bus = '1;
        end
    end

endmodule

// File: rtl/sbp_regbank.sv
// Module: bank of bus-loaded registers (pointers and latches). Each slot
// captures the bus on a rising edge when its load bit is set. Synchronous
// active-low reset clears all slots.
module sbp_regbank #(
    parameter int W = 8,
    parameter int N = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        ld,
    input  logic [W-1:0]        bus,
    output logic [N-1:0][W-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Load-enabled capture of the bus for one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (ld[g]) begin
                q[g] <= bus;
            end
        end
    end

endmodule

// File: rtl/sbp_step_ctr.sv
// Module: free-running microstep counter, cleared by a control bit and by
// synchronous active-low reset. Wraps naturally at its width.
module sbp_step_ctr #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [SW-1:0] step
);

    // Advance every cycle, or return to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

endmodule

// File: rtl/sbp_datapath.sv
// Module: top of the single-bus stack processor datapath. Decodes the
// control word, selects one bus driver, updates the register bank, carry
// flag and step counter. Assumes an external sequencer that asserts at most
// one bus driver per cycle and a memory with combinational read.
module sbp_datapath
    import sbp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       ctrl_word,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] insn_o,
    output logic              carry_o,
    output logic [STEP_W-1:0] step_o
);

    ctrl_t                          cw;
    logic [NUM_DRV-1:0]             drv_sel;
    logic [NUM_DRV-1:0][DATA_W-1:0] drv_src;
    logic [NUM_REG-1:0]             reg_ld;
    logic [NUM_REG-1:0][DATA_W-1:0] reg_q;
    logic [DATA_W-1:0]              bus;
    logic [DATA_W-1:0]              sum_v;
    logic [DATA_W-1:0]              nand_v;
    logic                           cout_v;
    logic                           zero_v;
    logic                           carry_q;

    // Decode the control word into named enables.
    always_comb begin
        cw      = ctrl_t'(ctrl_word);
        drv_sel = drv_vec(cw);
        reg_ld  = ld_vec(cw);
    end

    sbp_alu #(.W(DATA_W)) u_alu (
        .cin    (cw.cin_set),
        .opx    (reg_q[RG_X]),
        .opy    (reg_q[RG_Y]),
        .opz    (reg_q[RG_Z]),
        .sum    (sum_v),
        .cout   (cout_v),
        .nand_q (nand_v),
        .zero   (zero_v)
    );

    // Collect the bus sources in slot order.
    always_comb begin
        drv_src          = '0;
        drv_src[DV_NAND] = nand_v;
        drv_src[DV_SUM]  = sum_v;
        drv_src[DV_SPTR] = reg_q[RG_SPTR];
        drv_src[DV_IPTR] = reg_q[RG_IPTR];
        drv_src[DV_MEM]  = mem_rdata;
    end

    sbp_bus_mux #(.W(DATA_W), .N(NUM_DRV)) u_bus (
        .sel (drv_sel),
        .src (drv_src),
        .bus (bus)
    );

    sbp_regbank #(.W(DATA_W), .N(NUM_REG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (reg_ld),
        .bus   (bus),
        .q     (reg_q)
    );

    sbp_step_ctr #(.SW(STEP_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cw.clr_step),
        .step  (step_o)
    );

    // Carry flag: adder carry-out while summing, else the NAND zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (cw.ld_carry) begin
            carry_q <= cw.drv_sum ? cout_v : zero_v;
        end
    end

    // Drive the outward-facing ports.
    always_comb begin
        mem_addr  = reg_q[RG_ADDR];
        insn_o    = reg_q[RG_INSN];
        mem_wdata = bus;
        mem_we    = cw.mem_wr;
        carry_o   = carry_q;
    end

endmodule

// File: rtl/sbp_datapath_chk.sv
// Module: assertion checker for sbp_datapath, attached by bind. Observes
// ports only; assumes the synchronous active-low reset of the datapath.
module sbp_datapath_chk #(
    parameter int DATA_W = 8,
    parameter int STEP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        drv_sel,
    input logic              ld_carry,
    input logic              ld_insn,
    input logic              ld_addr,
    input logic              wr_bit,
    input logic              clr_bit,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic [DATA_W-1:0] insn_o,
    input logic              carry_o,
    input logic [STEP_W-1:0] step_o
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_addr == '0 && insn_o == '0 && carry_o == 1'b0 && step_o == '0));

    p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_sel));

    p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_sel == '0) |-> (mem_wdata == '1));

    p_addr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr |=> (mem_addr == $past(mem_wdata)));

    p_insn_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_insn |=> (insn_o == $past(mem_wdata)));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_addr |=> $stable(mem_addr));

    p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_carry |=> $stable(carry_o));

    p_mem_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drv_sel[4] |-> (mem_wdata == mem_rdata));

    p_write_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we == wr_bit);

    p_step_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bit |=> (step_o == '0));

    p_step_incr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_bit |=> (step_o == STEP_W'($past(step_o) + 1'b1)));

endmodule

bind sbp_datapath sbp_datapath_chk #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_sel   ({ctrl_word[6], ctrl_word[3:0]}),
    .ld_carry  (ctrl_word[13]),
    .ld_insn   (ctrl_word[12]),
    .ld_addr   (ctrl_word[11]),
    .wr_bit    (ctrl_word[7]),
    .clr_bit   (ctrl_word[5]),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .insn_o    (insn_o),
    .carry_o   (carry_o),
    .step_o    (step_o)
);

// File: tb/tb_sbp_datapath.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped alongside the datapath and
// compared on every clock.
module tb_sbp_datapath;

    // R2: control-word bit positions.
    localparam logic [15:0] C_LIP  = 16'h8000;
    localparam logic [15:0] C_LSP  = 16'h4000;
    localparam logic [15:0] C_LCF  = 16'h2000;
    localparam logic [15:0] C_LIL  = 16'h1000;
    localparam logic [15:0] C_LAL  = 16'h0800;
    localparam logic [15:0] C_LX   = 16'h0400;
    localparam logic [15:0] C_LY   = 16'h0200;
    localparam logic [15:0] C_LZ   = 16'h0100;
    localparam logic [15:0] C_WR   = 16'h0080;
    localparam logic [15:0] C_DMEM = 16'h0040;
    localparam logic [15:0] C_CLR  = 16'h0020;
    localparam logic [15:0] C_CIN  = 16'h0010;
    localparam logic [15:0] C_DIP  = 16'h0008;
    localparam logic [15:0] C_DSP  = 16'h0004;
    localparam logic [15:0] C_DSUM = 16'h0002;
    localparam logic [15:0] C_DNND = 16'h0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_addr, mem_wdata, insn_o;
    logic        mem_we, carry_o;
    logic [4:0]  step_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state.
    int m_ip, m_sp, m_cf, m_il, m_al, m_x, m_y, m_z, m_sc;

    always #2 clk = ~clk;

    sbp_datapath dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .insn_o(insn_o), .carry_o(carry_o), .step_o(step_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One cycle: drive, compare bus, clock, update model, compare state.
    task automatic cycle(input logic [15:0] cw, input logic [7:0] rd, input bit rst);
        int    bus_e, sum_full, nand_e, ndrv;
        string tag;
        @(negedge clk);
        ctrl_word = cw;
        mem_rdata = rd;
        rst_n     = ~rst;
        #0.5;
        sum_full = m_x + m_y + ((cw & C_CIN) != 0 ? 1 : 0);
        nand_e   = (~(m_y & m_z)) & 8'hFF;
        ndrv = 0;
        bus_e = 8'hFF;
        tag = "R3";
        if ((cw & C_DMEM) != 0) begin bus_e = rd;               tag = "R10"; ndrv++; end
        if ((cw & C_DIP)  != 0) begin bus_e = m_ip;             tag = "R4";  ndrv++; end
        if ((cw & C_DSP)  != 0) begin bus_e = m_sp;             tag = "R4";  ndrv++; end
        if ((cw & C_DSUM) != 0) begin bus_e = sum_full & 8'hFF; tag = "R6";  ndrv++; end
        if ((cw & C_DNND) != 0) begin bus_e = nand_e;           tag = "R7";  ndrv++; end
        if (ndrv > 1) $display("bench scenario error: several drivers");
        if (!rst) begin
            check(mem_wdata == 8'(bus_e), tag, mem_wdata, bus_e);
            check(mem_we == ((cw & C_WR) != 0), "R10", mem_we, int'((cw & C_WR) != 0));
        end
        @(posedge clk);
        if (rst) begin
            m_ip = 0; m_sp = 0; m_cf = 0; m_il = 0; m_al = 0;
            m_x = 0; m_y = 0; m_z = 0; m_sc = 0;
        end else begin
            if ((cw & C_LCF) != 0)
                m_cf = ((cw & C_DSUM) != 0) ? int'(sum_full > 255) : int'(nand_e == 0);
            if ((cw & C_LIP) != 0) m_ip = bus_e;
            if ((cw & C_LSP) != 0) m_sp = bus_e;
            if ((cw & C_LIL) != 0) m_il = bus_e;
            if ((cw & C_LAL) != 0) m_al = bus_e;
            if ((cw & C_LX)  != 0) m_x  = bus_e;
            if ((cw & C_LY)  != 0) m_y  = bus_e;
            if ((cw & C_LZ)  != 0) m_z  = bus_e;
            m_sc = ((cw & C_CLR) != 0) ? 0 : (m_sc + 1) % 32;
        end
        #0.5;
        if (rst) begin
            check(mem_addr == 0 && insn_o == 0 && carry_o == 0 && step_o == 0, "R1",
                  {mem_addr, insn_o, 3'b0, carry_o, 3'b0, step_o}, 0);
        end else begin
            check(mem_addr == 8'(m_al), "R5", mem_addr, m_al);
            check(insn_o == 8'(m_il), "R5", insn_o, m_il);
            check(carry_o == m_cf[0], ((cw & C_DSUM) != 0 || (cw & C_LCF) == 0) ? "R8" : "R9",
                  carry_o, m_cf);
            check(step_o == 5'(m_sc), "R11", step_o, m_sc);
        end
    endtask

    initial begin
        m_ip = 0; m_sp = 0; m_cf = 0; m_il = 0; m_al = 0;
        m_x = 0; m_y = 0; m_z = 0; m_sc = 0;
        // R1: reset while loads are requested.
        cycle(C_LIP | C_LX | C_LCF | C_DMEM, 8'hA5, 1);
        cycle(C_LAL | C_DMEM, 8'h5A, 1);
        // R3: idle bus loads all ones into the instruction latch.
        cycle(C_LIL, 8'h00, 0);
        // R10: memory onto the bus, into X, Y and the address latch.
        cycle(C_DMEM | C_LX, 8'h3C, 0);
        cycle(C_DMEM | C_LY | C_WR, 8'hD5, 0);
        cycle(C_DMEM | C_LAL, 8'h77, 0);
        // R6, R8: sum with carry-out into address latch and carry flag.
        cycle(C_DSUM | C_LCF | C_LAL, 8'h00, 0);
        // R6: sum with carry-in into the instruction pointer.
        cycle(C_DSUM | C_CIN | C_LIP, 8'h00, 0);
        // R4: pointer round trips, observed on the bus.
        cycle(C_DIP | C_LSP, 8'h00, 0);
        cycle(C_DSP | C_WR | C_LIL, 8'h00, 0);
        cycle(C_DIP | C_LIL, 8'h00, 0);
        // R9: NAND zero flag set, then cleared.
        cycle(C_DMEM | C_LY | C_LZ, 8'hFF, 0);
        cycle(C_DNND | C_LCF, 8'h00, 0);
        cycle(C_DMEM | C_LZ, 8'h0F, 0);
        cycle(C_DNND | C_LCF | C_LAL, 8'h00, 0);
        // R8: sum wraps to zero with carry-out (X=0xFF, Y=0x00, cin).
        cycle(C_DMEM | C_LX, 8'hFF, 0);
        cycle(C_DMEM | C_LY, 8'h00, 0);
        cycle(C_DSUM | C_CIN | C_LCF | C_LIL, 8'h00, 0);
        cycle(C_DSUM | C_LCF, 8'h00, 0);
        // R11: clear, then run past the wrap.
        cycle(C_CLR, 8'h00, 0);
        for (int i = 0; i < 36; i++) cycle(16'h0000, 8'h00, 0);
        cycle(C_CLR | C_DSP, 8'h00, 0);
        // Mixed traffic, one driver per cycle.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] cw;
            int pick;
            pick = $urandom_range(0, 5);
            cw = {8'($urandom()), 1'($urandom()), 1'b0,
                  1'($urandom_range(0, 9) == 0), 1'($urandom()), 4'b0000};
            case (pick)
                1: cw = cw | C_DMEM;
                2: cw = cw | C_DIP;
                3: cw = cw | C_DSP;
                4: cw = cw | C_DSUM;
                5: cw = cw | C_DNND;
                default: ;
            endcase
            cycle(cw, 8'($urandom()), 0);
        end
        // R1: reset mid-run.
        cycle(C_DMEM | C_LAL, 8'h99, 1);
        cycle(16'h0000, 8'h00, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule